// File: doc/BRIEF.md
# Nibble Sequence Code Detector

This block watches a stream of 4-bit digits and raises a flag once a programmed four-digit code has arrived, in order, on consecutive accepted digits. Digits are offered on a digit bus and qualified by a read strobe. One digit is taken for each rising edge of that strobe, and the strobe may come from a slower or unrelated source. The strobe passes through a two-stage synchroniser and an edge detector before it reaches the datapath. The digit bus itself is not synchronised, so a source must hold a digit stable while its strobe is high.

Alongside detection, the block keeps an 8-bit running total of every accepted digit. The total runs from reset through the digit that completes the code. A small control FSM hunts for the code and then freezes the flag and the total. It stays frozen until reset.

There is no valid/ready handshake and no back-pressure. The source paces itself with the strobe, and the block can always take a digit. The strobe must stay low long enough for the synchroniser to see each rising edge (three clock cycles is enough).

Top module: `code_seq_detect`

## Requirements
- R1: The code word holds four digits ordered in time. Bits [3:0] are the first digit expected, [7:4] the second, [11:8] the third and [15:12] the last.
- R2: A digit is taken once per rising edge of `rd_strobe`. While the strobe is low the digit bus is ignored, and holding the strobe high takes no further digits.
- R3: An accepted digit shows up on `sum_o` (and on `match_o` if it completes the code) after the third rising clock edge, counted from the first edge that samples the strobe high. After two edges the outputs still show the previous state.
- R4: `match_o` goes to 1 only when the last four accepted digits equal the code in order. Matches may overlap, so an earlier partial match that fails still lets a later one succeed.
- R5: `sum_o` equals the total of every accepted digit since reset, including the digit that completes the match.
- R6: Once `match_o` is 1, both `match_o` and `sum_o` hold their values and further strobes are ignored until reset.
- R7: Synchronous active-high `rst` clears `match_o`, `sum_o`, the digit history and the strobe edge detector.
- R8: `sum_o` wraps modulo 256 when the total exceeds 255 before a match.
- R9: No match is declared before four digits have been accepted since reset, even for code 0x0000.
- R10: With code 0x2601 and digits 0,1,3,0,3,4,1,0,2,1,1,0,6,2, `match_o` rises after the final digit only, and `sum_o` reads 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_word | input | 16 | Four-digit code, first digit in bits [3:0] |
| digit_in | input | 4 | Offered digit, held stable while strobe is high |
| rd_strobe | input | 1 | Read strobe; each rising edge takes one digit |
| match_o | output | 1 | Code detected; held until reset |
| sum_o | output | 8 | Running total of accepted digits, modulo 256 |

## Verification
The bench builds the block with its default parameters: four-digit codes of 4-bit digits, an 8-bit total and a two-stage strobe synchroniser. With an 8-bit total, a run of eighteen digits of value 15 carries the total past 255, so the wrap case fits in a short directed test. With a four-entry window, overlap cases such as code 1,1,1,2 against input 1,1,1,1,2 and the all-zero code before the window has filled need only a few digits. With two sync stages, the exact three-edge acceptance point can be pinned by sampling between edges.

// File: rtl/code_seq_pkg.sv
package code_seq_pkg;
  typedef enum logic [0:0] {
    CS_HUNT = 1'b0,
    CS_DONE = 1'b1
  } cs_state_e;
endpackage

// File: rtl/code_seq_strobe_edge.sv
module code_seq_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= strobe_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/code_seq_history.sv
module code_seq_history #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 4,
  localparam int CODE_W    = DIGIT_W * NUM_DIGITS,
  localparam int FILL_W    = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [DIGIT_W-1:0] digit,
  input  logic [CODE_W-1:0]  code,
  output logic              hit
);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(NUM_DIGITS - 1);

  logic [NUM_DIGITS-2:0][DIGIT_W-1:0] hist_q;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] window;
  logic [NUM_DIGITS-1:0]              eq;
  logic [FILL_W-1:0]                  fill_q;

  // window[0] is the incoming digit (newest); window[k] is k digits older
  assign window[0] = digit;
  genvar k;
  generate
    for (k = 1; k < NUM_DIGITS; k++) begin : g_win
      assign window[k] = hist_q[k-1];
    end
    for (k = 0; k < NUM_DIGITS; k++) begin : g_cmp
      // newest digit pairs with the last code digit (highest slice)
      assign eq[k] = (window[k] == code[(NUM_DIGITS-1-k)*DIGIT_W +: DIGIT_W]);
    end
  endgenerate

  assign hit = (&eq) && (fill_q == FILL_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= window[NUM_DIGITS-2:0];
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/code_seq_accum.sv
module code_seq_accum #(
  parameter int DIGIT_W = 4,
  parameter int SUM_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add_en,
  input  logic [DIGIT_W-1:0] digit,
  output logic [SUM_W-1:0]   sum
);
  localparam int PAD_W = SUM_W - DIGIT_W;

  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst)         sum_q <= '0;
    else if (add_en) sum_q <= sum_q + {{PAD_W{1'b0}}, digit};
  end

  assign sum = sum_q;
endmodule

// File: rtl/code_seq_ctrl.sv
module code_seq_ctrl
  import code_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic hit,
  output logic take,
  output logic matched
);
  cs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CS_HUNT: if (accept && hit) state_d = CS_DONE;
      CS_DONE: state_d = CS_DONE;
      default: state_d = CS_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= CS_HUNT;
    else     state_q <= state_d;
  end

  assign take    = accept && (state_q == CS_HUNT);
  assign matched = (state_q == CS_DONE);
endmodule

// File: rtl/code_seq_detect.sv
module code_seq_detect #(
  parameter int DIGIT_W     = 4,
  parameter int NUM_DIGITS  = 4,
  parameter int SUM_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = DIGIT_W * NUM_DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code_word,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               rd_strobe,
  output logic               match_o,
  output logic [SUM_W-1:0]   sum_o
);
  logic accept_pulse;
  logic take;
  logic hit;

  code_seq_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk          (clk),
    .rst          (rst),
    .strobe_async (rd_strobe),
    .rise_pulse   (accept_pulse)
  );

  code_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept_pulse),
    .hit     (hit),
    .take    (take),
    .matched (match_o)
  );

  code_seq_history #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (take),
    .digit    (digit_in),
    .code     (code_word),
    .hit      (hit)
  );

  code_seq_accum #(.DIGIT_W(DIGIT_W), .SUM_W(SUM_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .add_en (take),
    .digit  (digit_in),
    .sum    (sum_o)
  );
endmodule

// File: rtl/code_seq_detect_chk.sv
module code_seq_detect_chk #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 4,
  parameter int SUM_W      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               accept,
  input logic [DIGIT_W-1:0] digit_in,
  input logic               match_o,
  input logic [SUM_W-1:0]   sum_o
);
  localparam int CNT_W = $clog2(NUM_DIGITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_DIGITS);

  logic [CNT_W-1:0] seen_q;
  logic [SUM_W-1:0] next_sum;

  assign next_sum = sum_o + {{(SUM_W-DIGIT_W){1'b0}}, digit_in};

  always_ff @(posedge clk) begin
    if (rst)                              seen_q <= '0;
    else if (accept && seen_q != CNT_MAX) seen_q <= seen_q + 1'b1;
  end

  // R2
  accept_single_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);

  // R2
  sum_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(sum_o));

  // R5
  sum_add_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !match_o) |=> (sum_o == $past(next_sum)));

  // R6
  match_hold_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |=> match_o);

  // R6
  sum_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |=> $stable(sum_o));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!match_o && sum_o == '0));

  // R9
  early_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(match_o) |-> (seen_q == CNT_MAX));
endmodule

bind code_seq_detect code_seq_detect_chk #(
  .DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .SUM_W(SUM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .accept   (accept_pulse),
  .digit_in (digit_in),
  .match_o  (match_o),
  .sum_o    (sum_o)
);

// File: tb/test_code_seq_detect.sv
`timescale 1ns/1ps
module test_code_seq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] code_word = '0;
  logic [3:0]  digit_in = '0;
  logic        rd_strobe = 1'b0;
  logic        match_o;
  logic [7:0]  sum_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  code_seq_detect i_code_seq_detect (
    .clk       (clk),
    .rst       (rst),
    .code_word (code_word),
    .digit_in  (digit_in),
    .rd_strobe (rd_strobe),
    .match_o   (match_o),
    .sum_o     (sum_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [3:0] d);
    @(negedge clk);
    digit_in = d; rd_strobe = 1'b1;
    repeat (4) @(negedge clk);
    rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R7 match after reset", match_o, 0);
    check("R7 sum after reset", sum_o, 0);
  endtask

  task automatic t_latency();
    code_word = 16'h1234;
    do_reset();
    @(negedge clk);
    digit_in = 4'd9; rd_strobe = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 sum after two edges", sum_o, 0);
    @(negedge clk);
    check("R3 sum after third edge", sum_o, 9);
    rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_example();
    logic [3:0] seq [14] = '{0,1,3,0,3,4,1,0,2,1,1,0,6,2};
    code_word = 16'h2601;
    do_reset();
    for (int i = 0; i < 14; i++) begin
      send(seq[i]);
      if (i == 12) check("R10 no match before last digit", match_o, 0);
    end
    check("R10 match after final digit", match_o, 1);
    check("R10 sum equals 24", sum_o, 24);
    // R6: further strobes are ignored once matched
    send(4'd5);
    send(4'd7);
    check("R6 match held", match_o, 1);
    check("R6 sum frozen", sum_o, 24);
    do_reset();
    check("R7 reset clears match", match_o, 0);
    check("R7 reset clears sum", sum_o, 0);
  endtask

  task automatic t_order();
    // R1: code 0x4321 means digits 1,2,3,4 in time
    code_word = 16'h4321;
    do_reset();
    send(4); send(3); send(2); send(1);
    check("R1 reversed order no match", match_o, 0);
    send(2); send(3); send(4);
    check("R1 in-order match", match_o, 1);
    check("R5 sum includes matching digits", sum_o, 19);
  endtask

  task automatic t_overlap();
    // R4: code 1,1,1,2 against 1,1,1,1,2
    code_word = 16'h2111;
    do_reset();
    send(1); send(1); send(1); send(1);
    check("R4 partial window no match", match_o, 0);
    send(2);
    check("R4 overlapping match", match_o, 1);
    check("R4 sum overlap", sum_o, 6);
  endtask

  task automatic t_strobe();
    code_word = 16'h1234;
    do_reset();
    // bus ignored while strobe low
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      digit_in = 4'(i + 3);
    end
    check("R2 bus ignored while low", sum_o, 0);
    // strobe held high takes only one digit
    @(negedge clk);
    digit_in = 4'd5; rd_strobe = 1'b1;
    repeat (6) @(negedge clk);
    digit_in = 4'd7;
    repeat (8) @(negedge clk);
    check("R2 held strobe one digit", sum_o, 5);
    rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    send(4'd2);
    check("R2 next rising edge taken", sum_o, 7);
  endtask

  task automatic t_wrap();
    code_word = 16'h1234;
    do_reset();
    for (int i = 0; i < 18; i++) send(4'hF);
    check("R8 sum wraps modulo 256", sum_o, 14);
    check("R8 no match during wrap", match_o, 0);
  endtask

  task automatic t_zero_code();
    code_word = 16'h0000;
    do_reset();
    send(0); send(0); send(0);
    check("R9 no match after three digits", match_o, 0);
    send(0);
    check("R9 match after fourth digit", match_o, 1);
    check("R9 sum zero", sum_o, 0);
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_example();
    t_order();
    t_overlap();
    t_strobe();
    t_wrap();
    t_zero_code();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule